// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Read Sequencer

This block sits in the FPGA fabric and runs an eight-channel, simultaneous-sampling converter that has a 16-bit parallel output bus. A free-running period counter sets the sample rate. On each period the sequencer raises both conversion-start lines together. It then waits for the converter's busy flag to rise and fall, and reads the results one channel at a time. Chip select stays low for the whole read, while the read strobe pulses low once per channel. The oversampling select pins are held at the no-oversampling code.

Three frame modes are offered:

- **Full frame:** all eight channels are read.
- **Short frame:** reading stops after the first four channels, and chip select returns high.
- **Fallback:** only the group-A start line is pulsed and busy is ignored. The sequencer waits a fixed maximum conversion time and then reads the first four channels.

Each captured word leaves the block with its channel index and a one-cycle valid pulse, and a frame-done pulse closes each completed frame. Two error pulses are provided. One marks a period that was skipped because a frame was still running. The other marks a conversion in which busy never rose.

Top module: `simsamp_rdseq`

## Requirements
- R1: The start lines rise every PERIOD_CYC clock cycles; the default of 625 gives 5 us at 125 MHz. Each start pulse is high for START_CYC cycles. When a period is skipped by R10, the next rise comes one further PERIOD_CYC later.
- R2: Outside fallback mode, `conv_a` and `conv_b` rise in the same cycle and fall in the same cycle.
- R3: `os_sel` is always 3'b000 (no oversampling), including during reset.
- R4: Outside fallback mode, reading begins only after busy has been seen high and then low. `rd_n` is never low while `busy` is high.
- R5: `cs_n` stays low from the first read strobe of a frame to the last. `rd_n` falls only while `cs_n` is low. Each `rd_n` low phase lasts RD_LO_CYC cycles, and each high phase between strobes of one frame lasts RD_HI_CYC cycles.
- R6: `db` is captured in the last low cycle of each strobe. The captured word is output on `smp_data` with `smp_chan` set to the channel index (0 = first channel, ascending). `smp_valid` is high for exactly one cycle per word.
- R7: With `mode_four`=1, exactly four strobes are issued per frame (channels 0 to 3). `cs_n` then returns high and no further strobe follows in that frame.
- R8: With `mode_fallback`=1 (this overrides `mode_four`), only `conv_a` pulses and `conv_b` stays low. Busy is ignored. The first `rd_n` fall comes exactly MAXCONV_CYC cycles after `conv_a` falls, and channels 0 to 3 are read.
- R9: `frame_done` is a one-cycle pulse that comes RD_HI_CYC cycles after the last strobe of a frame rises. `cs_n` goes high in the same cycle, and by then the frame has delivered 4 or 8 valid words as its mode requires.
- R10: If a period elapses while a frame is still running, `overrun` pulses for one cycle and that period starts no conversion.
- R11: Outside fallback mode, if the synchronised busy flag has not risen BUSY_TO_CYC cycles after the start pulse ends, `busy_timeout` pulses exactly then. The frame is dropped with no strobe and no `frame_done`.
- R12: `mode_four` and `mode_fallback` are sampled when a start pulse begins. A change during a frame takes effect from the next frame.
- R13: While `rst` is high and after it, until the first period, `cs_n`, `rd_n` are 1 and `conv_a`, `conv_b`, `smp_valid`, `frame_done`, `overrun`, `busy_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_four | input | 1 | 1: read only channels 0 to 3 |
| mode_fallback | input | 1 | 1: group-A start only, fixed wait, 4 channels |
| busy | input | 1 | Converter busy flag (asynchronous) |
| db | input | 16 | Converter parallel data bus |
| conv_a | output | 1 | Conversion start, channel group A |
| conv_b | output | 1 | Conversion start, channel group B |
| os_sel | output | 3 | Oversampling select, fixed 000 |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| smp_data | output | 16 | Captured sample |
| smp_chan | output | 3 | Channel index of smp_data |
| smp_valid | output | 1 | One-cycle valid for smp_data |
| frame_done | output | 1 | One-cycle pulse after the last channel |
| overrun | output | 1 | One-cycle pulse: period skipped |
| busy_timeout | output | 1 | One-cycle pulse: busy never rose |

## Verification
A wrong channel counter or a mode latched at the wrong time shows within the same frame. It appears either as a `smp_chan` or `smp_data` mismatch at the next valid pulse, or as a wrong word count when `frame_done` arrives. A stall in a wait state leaves `cs_n` high, and the next period then produces an `overrun` pulse. A drifting period counter is caught at the next start rise by the exact interval check. Strobe counter faults show as a low or high phase one cycle off on the very next strobe.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;
  localparam int CHAN_W = 3;
  localparam logic [2:0] OS_NONE = 3'b000;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_WRISE,
    S_WFALL,
    S_WMAX,
    S_RLO,
    S_RHI
  } seq_st_t;
endpackage

// File: rtl/simsamp_tick.sv
module simsamp_tick #(
  parameter int PERIOD_CYC = 625
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = $clog2(PERIOD_CYC);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (cnt == PW'(PERIOD_CYC - 1)) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/simsamp_ctrl.sv
module simsamp_ctrl
  import simsamp_pkg::*;
#(
  parameter int START_CYC   = 4,
  parameter int RD_LO_CYC   = 4,
  parameter int RD_HI_CYC   = 3,
  parameter int MAXCONV_CYC = 500,
  parameter int BUSY_TO_CYC = 600,
  parameter int CNT_W       = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              mode_four,
  input  logic              mode_fallback,
  input  logic              busy,
  output logic              conv_a,
  output logic              conv_b,
  output logic              cs_n,
  output logic              rd_n,
  output logic              cap_en,
  output logic [CHAN_W-1:0] cap_chan,
  output logic              frame_done,
  output logic              overrun,
  output logic              busy_timeout
);
  seq_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        bsync;
  logic              busy_s;
  logic              four_q, fb_q;
  logic [CHAN_W-1:0] ch;
  logic [CHAN_W-1:0] last_ch;

  assign busy_s   = bsync[1];
  assign last_ch  = four_q ? CHAN_W'(3) : CHAN_W'(7);
  assign cap_en   = (st == S_RLO) && (cnt == CNT_W'(RD_LO_CYC - 1));
  assign cap_chan = ch;

  always_ff @(posedge clk) begin
    if (rst) bsync <= 2'b00;
    else     bsync <= {bsync[0], busy};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      cnt          <= '0;
      conv_a       <= 1'b0;
      conv_b       <= 1'b0;
      cs_n         <= 1'b1;
      rd_n         <= 1'b1;
      frame_done   <= 1'b0;
      overrun      <= 1'b0;
      busy_timeout <= 1'b0;
      four_q       <= 1'b0;
      fb_q         <= 1'b0;
      ch           <= '0;
    end else begin
      frame_done   <= 1'b0;
      overrun      <= 1'b0;
      busy_timeout <= 1'b0;
      if (tick && st != S_IDLE) overrun <= 1'b1;
      case (st)
        S_IDLE: if (tick) begin
          st     <= S_START;
          cnt    <= '0;
          conv_a <= 1'b1;
          conv_b <= !mode_fallback;
          fb_q   <= mode_fallback;
          four_q <= mode_four | mode_fallback;
          ch     <= '0;
        end
        S_START: if (cnt == CNT_W'(START_CYC - 1)) begin
          conv_a <= 1'b0;
          conv_b <= 1'b0;
          cnt    <= '0;
          st     <= fb_q ? S_WMAX : S_WRISE;
        end else cnt <= cnt + 1'b1;
        S_WRISE: if (busy_s) begin
          st  <= S_WFALL;
          cnt <= '0;
        end else if (cnt == CNT_W'(BUSY_TO_CYC - 1)) begin
          busy_timeout <= 1'b1;
          cnt          <= '0;
          st           <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_WFALL: if (!busy_s) begin
          st   <= S_RLO;
          cs_n <= 1'b0;
          rd_n <= 1'b0;
          cnt  <= '0;
        end
        S_WMAX: if (cnt == CNT_W'(MAXCONV_CYC - 1)) begin
          st   <= S_RLO;
          cs_n <= 1'b0;
          rd_n <= 1'b0;
          cnt  <= '0;
        end else cnt <= cnt + 1'b1;
        S_RLO: if (cnt == CNT_W'(RD_LO_CYC - 1)) begin
          rd_n <= 1'b1;
          cnt  <= '0;
          st   <= S_RHI;
        end else cnt <= cnt + 1'b1;
        S_RHI: if (cnt == CNT_W'(RD_HI_CYC - 1)) begin
          cnt <= '0;
          if (ch == last_ch) begin
            cs_n       <= 1'b1;
            frame_done <= 1'b1;
            st         <= S_IDLE;
          end else begin
            ch   <= ch + 1'b1;
            rd_n <= 1'b0;
            st   <= S_RLO;
          end
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_no_read_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !fb_q) |-> !busy_s);
  assert_rd_inside_cs_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !cs_n);
  assert_short_frame_chan_R7: assert property (@(posedge clk) disable iff (rst)
    (cap_en && four_q) |-> (cap_chan < CHAN_W'(4)));
  assert_fallback_no_b_R8: assert property (@(posedge clk) disable iff (rst)
    (fb_q && st != S_IDLE) |-> !conv_b);
  assert_ab_together_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(conv_a) && !mode_fallback) |=> conv_b);
  assert_overrun_busy_R10: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(st) != S_IDLE);
  assert_pulses_apart_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_done, busy_timeout, cap_en}));
endmodule

// File: rtl/simsamp_capture.sv
module simsamp_capture
  import simsamp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [CHAN_W-1:0] cap_chan,
  input  logic [DATA_W-1:0] db,
  output logic [DATA_W-1:0] smp_data,
  output logic [CHAN_W-1:0] smp_chan,
  output logic              smp_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_data  <= '0;
      smp_chan  <= '0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= cap_en;
      if (cap_en) begin
        smp_data <= db;
        smp_chan <= cap_chan;
      end
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);
endmodule

// File: rtl/simsamp_rdseq.sv
module simsamp_rdseq
  import simsamp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PERIOD_CYC  = 625,
  parameter int START_CYC   = 4,
  parameter int RD_LO_CYC   = 4,
  parameter int RD_HI_CYC   = 3,
  parameter int MAXCONV_CYC = 500,
  parameter int BUSY_TO_CYC = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_four,
  input  logic              mode_fallback,
  input  logic              busy,
  input  logic [DATA_W-1:0] db,
  output logic              conv_a,
  output logic              conv_b,
  output logic [2:0]        os_sel,
  output logic              cs_n,
  output logic              rd_n,
  output logic [DATA_W-1:0] smp_data,
  output logic [2:0]        smp_chan,
  output logic              smp_valid,
  output logic              frame_done,
  output logic              overrun,
  output logic              busy_timeout
);
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXP  = max2(max2(max2(START_CYC, RD_LO_CYC), RD_HI_CYC),
                              max2(MAXCONV_CYC, BUSY_TO_CYC));
  localparam int CNT_W = $clog2(MAXP + 1);

  logic              tick;
  logic              cap_en;
  logic [CHAN_W-1:0] cap_chan;

  assign os_sel = OS_NONE;

  simsamp_tick #(.PERIOD_CYC(PERIOD_CYC)) i_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  simsamp_ctrl #(
    .START_CYC  (START_CYC),
    .RD_LO_CYC  (RD_LO_CYC),
    .RD_HI_CYC  (RD_HI_CYC),
    .MAXCONV_CYC(MAXCONV_CYC),
    .BUSY_TO_CYC(BUSY_TO_CYC),
    .CNT_W      (CNT_W)
  ) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .mode_four    (mode_four),
    .mode_fallback(mode_fallback),
    .busy         (busy),
    .conv_a       (conv_a),
    .conv_b       (conv_b),
    .cs_n         (cs_n),
    .rd_n         (rd_n),
    .cap_en       (cap_en),
    .cap_chan     (cap_chan),
    .frame_done   (frame_done),
    .overrun      (overrun),
    .busy_timeout (busy_timeout)
  );

  simsamp_capture #(.DATA_W(DATA_W)) i_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .cap_chan (cap_chan),
    .db       (db),
    .smp_data (smp_data),
    .smp_chan (smp_chan),
    .smp_valid(smp_valid)
  );

  assert_os_fixed_R3: assert property (@(posedge clk) os_sel == 3'b000);
endmodule

// File: tb/test_simsamp_rdseq.sv
`timescale 1ns/1ps
module test_simsamp_rdseq;
  localparam int PER = 200, STW = 2, RLO = 3, RHI = 2, MAXC = 40, BTO = 30;

  logic clk = 1'b0, rst = 1'b1;
  logic mode_four = 1'b0, mode_fallback = 1'b0, busy = 1'b0;
  logic [15:0] db;
  logic conv_a, conv_b, cs_n, rd_n, smp_valid, frame_done, overrun, busy_timeout;
  logic [2:0] os_sel, smp_chan;
  logic [15:0] smp_data;

  always #4 clk = ~clk;

  simsamp_rdseq #(.PERIOD_CYC(PER), .START_CYC(STW), .RD_LO_CYC(RLO),
    .RD_HI_CYC(RHI), .MAXCONV_CYC(MAXC), .BUSY_TO_CYC(BTO)) i_simsamp_rdseq (
    .clk(clk), .rst(rst), .mode_four(mode_four), .mode_fallback(mode_fallback),
    .busy(busy), .db(db), .conv_a(conv_a), .conv_b(conv_b), .os_sel(os_sel),
    .cs_n(cs_n), .rd_n(rd_n), .smp_data(smp_data), .smp_chan(smp_chan),
    .smp_valid(smp_valid), .frame_done(frame_done), .overrun(overrun),
    .busy_timeout(busy_timeout));

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // converter model
  logic [15:0] words [8];
  int conv_cyc = 20;
  bit busy_en = 1;
  int bdly = 0, bcnt = 0, ptr = 0;
  logic a_q = 0, rd_q = 1;
  assign db = words[ptr[2:0]];

  always @(posedge clk) begin
    a_q  <= conv_a;
    rd_q <= rd_n;
    if (conv_a && !a_q) begin
      for (int i = 0; i < 8; i++) words[i] <= 16'($urandom);
      ptr <= 0;
      if (conv_b && busy_en) bdly <= 2;
    end else if (!rd_q && rd_n) ptr <= ptr + 1;
    if (bdly > 0) begin
      bdly <= bdly - 1;
      if (bdly == 1) begin busy <= 1'b1; bcnt <= conv_cyc; end
    end else if (busy) begin
      if (bcnt <= 1) busy <= 1'b0; else bcnt <= bcnt - 1;
    end
  end

  // monitor
  int cyc = 0, last_rise = 0, conv_fall = 0, rd_fall = 0, rd_rise = 0;
  int ovr_since = 0, ovr_total = 0, to_cnt = 0, frame_cnt = 0, nvalid = 0, exp_n = 8;
  bit have_rise = 0, first_rd = 1, exp_fb = 0;
  logic pa = 0, prd = 1;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (conv_a && !pa) begin
        if (have_rise)
          chk(cyc - last_rise == PER * (1 + ovr_since), "R1 period", cyc - last_rise, PER * (1 + ovr_since));
        last_rise = cyc; have_rise = 1; ovr_since = 0;
        exp_fb = mode_fallback;
        exp_n  = (mode_four || mode_fallback) ? 4 : 8;
        chk(conv_b == !exp_fb, exp_fb ? "R8 conv_b low" : "R2 conv_b with conv_a", conv_b, !exp_fb);
        chk(os_sel == 3'b000, "R3 os_sel", os_sel, 0);
        nvalid = 0; first_rd = 1;
      end
      if (!conv_a && pa) begin
        conv_fall = cyc;
        chk(cyc - last_rise == STW, "R1 start width", cyc - last_rise, STW);
        chk(conv_b == 1'b0, "R2 conv_b falls with conv_a", conv_b, 0);
      end
      if (overrun) begin ovr_since++; ovr_total++; end
      if (!rd_n && busy) chk(0, "R4 rd_n low during busy", 1, 0);
      if (!rd_n && prd) begin
        chk(cs_n == 1'b0, "R5 cs_n low at strobe", cs_n, 0);
        if (first_rd && exp_fb) chk(cyc - conv_fall == MAXC, "R8 fixed wait", cyc - conv_fall, MAXC);
        if (!first_rd) chk(cyc - rd_rise == RHI, "R5 high time", cyc - rd_rise, RHI);
        chk(nvalid < exp_n, "R7 strobe count", nvalid, exp_n - 1);
        first_rd = 0; rd_fall = cyc;
      end
      if (rd_n && !prd) begin
        rd_rise = cyc;
        chk(cyc - rd_fall == RLO, "R5 low time", cyc - rd_fall, RLO);
      end
      if (smp_valid) begin
        chk(smp_chan == 3'(nvalid), "R6 channel index", smp_chan, nvalid);
        chk(smp_data == words[nvalid[2:0]], "R6 data", smp_data, words[nvalid[2:0]]);
        nvalid++;
      end
      if (frame_done) begin
        frame_cnt++;
        chk(nvalid == exp_n, "R9 R7 words per frame", nvalid, exp_n);
        chk(cs_n == 1'b1, "R9 cs_n high", cs_n, 1);
        chk(cyc - rd_rise == RHI, "R9 done timing", cyc - rd_rise, RHI);
      end
      if (busy_timeout) begin
        to_cnt++;
        chk(cyc - conv_fall == BTO, "R11 timeout timing", cyc - conv_fall, BTO);
        chk(nvalid == 0 && cs_n, "R11 no read", nvalid, 0);
      end
    end
    pa = conv_a; prd = rd_n;
  end

  task automatic wait_frames(input int n);
    int t = frame_cnt + n;
    while (frame_cnt < t) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) words[i] = 16'h0;
    repeat (5) @(negedge clk);
    chk(cs_n && rd_n && !conv_a && !conv_b && !smp_valid && !frame_done && !overrun && !busy_timeout,
        "R13 reset state", {cs_n, rd_n, conv_a, conv_b}, 4'b1100);
    chk(os_sel == 3'b000, "R3 os_sel in reset", os_sel, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && rd_n && !conv_a, "R13 idle after reset", {cs_n, rd_n, conv_a}, 3'b110);
    // full frames, random conversion time
    for (int f = 0; f < 6; f++) begin
      conv_cyc = 10 + int'($urandom_range(50));
      wait_frames(1);
    end
    // R12: switch to short frame in the middle of a full frame
    while (cs_n) @(negedge clk);
    mode_four = 1'b1;
    wait_frames(1);
    for (int f = 0; f < 5; f++) begin
      conv_cyc = 10 + int'($urandom_range(50));
      wait_frames(1);
    end
    // fallback, with mode_four also set and cleared
    mode_fallback = 1'b1;
    wait_frames(2);
    mode_four = 1'b0;
    wait_frames(2);
    mode_fallback = 1'b0;
    // overrun: conversion longer than the period allows
    conv_cyc = 180;
    wait_frames(3);
    chk(ovr_total > 0, "R10 overrun seen", ovr_total, 1);
    conv_cyc = 20;
    wait_frames(1);
    // timeout: busy never rises
    busy_en = 0;
    while (to_cnt < 2) @(negedge clk);
    chk(to_cnt == 2, "R11 timeout count", to_cnt, 2);
    busy_en = 1;
    wait_frames(2);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule